// File: doc/BRIEF.md
# Bit-Ring Fixed Cycle Delay

This block replays a single-bit pulse stream a fixed number of clock cycles later. Each cycle's input value is kept on its own, so pulses that arrive back to back or overlap come out with the same spacing, each exactly `DELAY` cycles after it went in. A common use is timing the "must happen by cycle N" checks of a monitor or lining up a strobe with a pipeline of known depth.

The in-flight pulses are not held in a shift register of `DELAY` flip-flops. They sit in a `DELAY`-bit vector that is used as a circular buffer, with one slot index that moves forward every cycle. On each clock edge the slot under the index is first read as the output and then overwritten with the new input, so each cycle costs one indexed read, one indexed write and one index step. A busy flag ORs the whole vector together and reports whether any pulse is still in flight. A synchronous flush drops every pending pulse at once.

With `DELAY` of 0 the block is a wire. With `DELAY` of 1 it is a single flop and no ring is built.

Top module: `pulse_ring_delay`

## Requirements
- R1: With DELAY = 0, pulse_out equals pulse_in in the same cycle and pulse_busy stays 0.
- R2: With DELAY = 1, pulse_out during the cycle after a clock edge equals the pulse_in sampled at that edge, or 0 if flush was high at that edge.
- R3: With DELAY >= 2, pulse_out equals the pulse_in sampled DELAY clock edges earlier, provided no flush or reset edge came in between. This holds across every wrap of the slot index.
- R4: Back-to-back and overlapping pulses are kept separately, so a run of consecutive 1 inputs comes out as a run of the same length and position.
- R5: pulse_busy is 1 exactly when at least one input 1, sampled within the last DELAY edges and not removed by a later flush or reset, is still in flight (DELAY >= 1).
- R6: A flush edge drops every pending pulse and also drops the input sampled at that same edge. The slot index still moves forward at that edge, so inputs sampled after the flush come out exactly DELAY edges later.
- R7: A reset edge empties the storage and puts the index at slot 0. After reset, pulse_out (for DELAY >= 1) and pulse_busy are 0 until new input arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Input pulse stream, sampled each edge |
| flush | input | 1 | Synchronous clear of all pending pulses |
| pulse_out | output | 1 | Input stream delayed by DELAY cycles |
| pulse_busy | output | 1 | High while any pulse is in flight |

## Verification
On every cycle, the assertions check the following at the ports: the single-stage response, that a flush or reset leaves the busy flag low on the next cycle, that a delayed pulse on the output implies the busy flag, and that an idle block stays idle. The exact DELAY-cycle spacing cannot be seen by a short property for large DELAY. The same holds for run lengths kept across index wraps and for inputs sampled after a flush coming out on schedule. Only the bench's scenarios show these, by comparing several instances against a recorded input history.

// File: rtl/pulse_ring_delay_pkg.sv
package pulse_ring_delay_pkg;

    // Width of a slot index for a ring of the given depth (at least 1 bit).
    function automatic int unsigned slot_width(int unsigned depth);
        return (depth < 2) ? 1 : $clog2(depth);
    endfunction

    // Per-edge command applied to the ring storage.
    typedef struct packed {
        logic wipe;     // zero the whole ring instead of writing the slot
        logic fill;     // value written into the current slot
    } ring_cmd_t;

    // How the top is built for a given DELAY.
    typedef enum logic [1:0] {
        SHAPE_WIRE = 2'd0,
        SHAPE_FLOP = 2'd1,
        SHAPE_RING = 2'd2
    } delay_shape_e;

    function automatic delay_shape_e shape_for(int unsigned depth);
        if (depth == 0) return SHAPE_WIRE;
        if (depth == 1) return SHAPE_FLOP;
        return SHAPE_RING;
    endfunction

endpackage

// File: rtl/ring_slot_index.sv
module ring_slot_index #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned IW = pulse_ring_delay_pkg::slot_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [IW-1:0] slot
);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    logic [IW-1:0] slot_q;
    logic [IW-1:0] slot_nxt;

    // Wrap from the last slot back to 0, otherwise step by one.
    always_comb begin
        if (slot_q == LAST) slot_nxt = '0;
        else                slot_nxt = slot_q + IW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_nxt;
    end

    assign slot = slot_q;
endmodule

// File: rtl/ring_bit_store.sv
module ring_bit_store #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned IW = pulse_ring_delay_pkg::slot_width(DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [IW-1:0]                  slot,
    input  pulse_ring_delay_pkg::ring_cmd_t cmd,
    output logic                           rd_bit,
    output logic                           any_set
);
    logic [DEPTH-1:0] ring_q;

    // Read of the current slot comes from the register, before the edge's write.
    assign rd_bit  = ring_q[slot];
    assign any_set = |ring_q;

    always_ff @(posedge clk) begin
        if (rst || cmd.wipe) ring_q       <= '0;
        else                 ring_q[slot] <= cmd.fill;
    end
endmodule

// File: rtl/single_stage_delay.sv
module single_stage_delay (
    input  logic                           clk,
    input  logic                           rst,
    input  pulse_ring_delay_pkg::ring_cmd_t cmd,
    output logic                           q
);
    always_ff @(posedge clk) begin
        if (rst || cmd.wipe) q <= 1'b0;
        else                 q <= cmd.fill;
    end
endmodule

// File: rtl/pulse_ring_delay.sv
module pulse_ring_delay #(
    parameter int unsigned DELAY = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_in,
    input  logic flush,
    output logic pulse_out,
    output logic pulse_busy
);
    import pulse_ring_delay_pkg::*;

    localparam delay_shape_e SHAPE = shape_for(DELAY);

    ring_cmd_t cmd;
    assign cmd.wipe = flush;
    assign cmd.fill = pulse_in;

    generate
        if (SHAPE == SHAPE_WIRE) begin : g_wire
            assign pulse_out  = pulse_in;
            assign pulse_busy = 1'b0;
        end else if (SHAPE == SHAPE_FLOP) begin : g_flop
            logic stage_q;
            single_stage_delay u_stage (
                .clk (clk),
                .rst (rst),
                .cmd (cmd),
                .q   (stage_q)
            );
            assign pulse_out  = stage_q;
            assign pulse_busy = stage_q;
        end else begin : g_ring
            localparam int unsigned IW = slot_width(DELAY);
            logic [IW-1:0] slot;

            ring_slot_index #(.DEPTH(DELAY)) u_index (
                .clk  (clk),
                .rst  (rst),
                .slot (slot)
            );

            ring_bit_store #(.DEPTH(DELAY)) u_store (
                .clk     (clk),
                .rst     (rst),
                .slot    (slot),
                .cmd     (cmd),
                .rd_bit  (pulse_out),
                .any_set (pulse_busy)
            );
        end
    endgenerate
endmodule

// File: rtl/pulse_ring_delay_chk.sv
module pulse_ring_delay_chk #(
    parameter int unsigned DELAY = 1024
) (
    input logic clk,
    input logic rst,
    input logic pulse_in,
    input logic flush,
    input logic pulse_out,
    input logic pulse_busy
);
    generate
        if (DELAY == 1) begin : g_one
            // R2: one edge later the output shows the sampled input, or 0 after a flush
            assert_single_stage_R2: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (pulse_out == ($past(pulse_in) && !$past(flush))));
        end
        if (DELAY >= 1) begin : g_stored
            // R6: after a flush edge nothing is in flight
            assert_clear_drains_R6: assert property (@(posedge clk) disable iff (rst)
                flush |=> !pulse_busy);
            // R7: after a reset edge the block is idle
            assert_reset_idle_R7: assert property (@(posedge clk)
                rst |=> (!pulse_busy && !pulse_out));
            // R5: with no pulse entering, an idle block stays idle
            assert_idle_stays_R5: assert property (@(posedge clk) disable iff (rst)
                (!pulse_busy && !pulse_in) |=> !pulse_busy);
        end
        if (DELAY >= 2) begin : g_ring
            // R5: a pulse leaving the ring was still in flight
            assert_out_implies_busy_R5: assert property (@(posedge clk) disable iff (rst)
                pulse_out |-> pulse_busy);
        end
    endgenerate
endmodule

bind pulse_ring_delay pulse_ring_delay_chk #(.DELAY(DELAY)) u_chk (.*);

// File: tb/tb_pulse_ring_delay.sv
module tb_pulse_ring_delay;
    localparam int MAXE = 8192;
    localparam int RST_EDGES = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pulse_in = 1'b0;
    logic flush = 1'b0;

    always #5 clk = ~clk;

    logic o_big, b_big, o0, b0, o1, b1, o2, b2, o3, b3;

    pulse_ring_delay #(.DELAY(1024)) dut (
        .clk(clk), .rst(rst), .pulse_in(pulse_in), .flush(flush),
        .pulse_out(o_big), .pulse_busy(b_big));
    pulse_ring_delay #(.DELAY(0)) dut_n0 (
        .clk(clk), .rst(rst), .pulse_in(pulse_in), .flush(flush),
        .pulse_out(o0), .pulse_busy(b0));
    pulse_ring_delay #(.DELAY(1)) dut_n1 (
        .clk(clk), .rst(rst), .pulse_in(pulse_in), .flush(flush),
        .pulse_out(o1), .pulse_busy(b1));
    pulse_ring_delay #(.DELAY(2)) dut_n2 (
        .clk(clk), .rst(rst), .pulse_in(pulse_in), .flush(flush),
        .pulse_out(o2), .pulse_busy(b2));
    pulse_ring_delay #(.DELAY(3)) dut_n3 (
        .clk(clk), .rst(rst), .pulse_in(pulse_in), .flush(flush),
        .pulse_out(o3), .pulse_busy(b3));

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    bit hist[MAXE];
    int ones_before[MAXE+1];
    int last_kill = RST_EDGES - 1;
    int k = 0;
    bit burst_phase = 0;

    task automatic chk(string tag, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s edge=%0d actual=%b expected=%b", tag, what, k, act, exp);
        end
    endtask

    function automatic bit exp_out(int n, int e);
        int m;
        if (n == 0) return hist[e];
        m = e - n;
        if (m <= last_kill) return 1'b0;
        return hist[m];
    endfunction

    function automatic bit exp_busy(int n, int e);
        int lo;
        if (n == 0) return 1'b0;
        lo = e - n;
        if (lo < last_kill + 1) lo = last_kill + 1;
        if (lo > e - 1) return 1'b0;
        return (ones_before[e] - ones_before[lo]) > 0;
    endfunction

    task automatic check_one(int n, logic o, logic b);
        string t_out;
        string t_bsy;
        if (n == 0) t_out = "R1";
        else if (n == 1) t_out = "R2";
        else t_out = "R3";
        t_bsy = (n == 0) ? "R1" : "R5";
        if (burst_phase) t_out = "R4";
        if (n > 0 && last_kill > RST_EDGES - 1 && k - last_kill <= n + 1) begin
            t_out = "R6";
            t_bsy = "R6";
        end
        if (k == RST_EDGES) begin
            t_out = (n == 0) ? "R1" : "R7";
            t_bsy = (n == 0) ? "R1" : "R7";
        end
        chk(t_out, $sformatf("out N=%0d", n), o, exp_out(n, k));
        chk(t_bsy, $sformatf("busy N=%0d", n), b, exp_busy(n, k));
    endtask

    // One clock edge: drive at negedge, check outputs for this period, then clock.
    task automatic step(bit d, bit f);
        @(negedge clk);
        pulse_in = d;
        flush = f;
        hist[k] = d;
        #1;
        if (!rst) begin
            check_one(1024, o_big, b_big);
            check_one(0, o0, b0);
            check_one(1, o1, b1);
            check_one(2, o2, b2);
            check_one(3, o3, b3);
        end
        ones_before[k+1] = ones_before[k] + (d ? 1 : 0);
        if (f || rst) last_kill = k;
        k++;
    endtask

    task automatic idle(int cnt);
        for (int i = 0; i < cnt; i++) step(1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        ones_before[0] = 0;
        for (int i = 0; i < RST_EDGES; i++) step(1'b0, 1'b0);
        rst = 1'b0;

        // R7 first-cycle checks happen at k == RST_EDGES, then a directed lone pulse (R3)
        step(1'b1, 1'b0);
        idle(1100);

        // R3/R5: random pulse trains with occasional flush (R6)
        for (int i = 0; i < 2500; i++) begin
            bit d = ($urandom_range(0, 9) < 3);
            bit f = ($urandom_range(0, 249) == 0);
            step(d, f);
        end
        idle(1030);

        // R4: back-to-back runs of different lengths
        burst_phase = 1;
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 20; i++) step(i[0], 1'b0);
        idle(1030);
        burst_phase = 0;

        // R6: flush in the middle of a dense burst, input at the flush edge is dropped
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
        idle(1030);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R3 watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule